// File: doc/BRIEF.md
# Escalating Three-Stage Watchdog

This block is a single-channel hardware watchdog. A prescaler divides the input clock into coarse ticks, and a down-counter steps once per tick. Each time the counter runs out it reloads from a software-set length and moves one stage up an escalation ladder. The first run-out raises a CPU interrupt. The second run-out raises an interrupt to a management processor. The third run-out requests a system reset. A two-bit mode selects how many of these stages are active. Software keeps the system alive by writing a poke value, which reloads the counter and drops the ladder back to its first stage.

Software reaches the block through a plain 64-bit register strobe port. The port gives access to a control word that holds the mode, the reload length and the live count. It also gives access to a pending-status word, a pair of write-one enable-set and enable-clear words, and a poke word. Reads are combinational from the address. Writes take effect at the clock edge on which `reg_wr` is high. Address bits [2:0] must be zero for a register to be selected.

Top module: `wdt_escalate`

## Requirements
- R1: After reset, `irq_cpu`, `irq_mgmt` and `rst_req` are low, and the control, pending and enable registers read as zero.
- R2: The register map uses byte addresses: control 0x00, pending 0x08, enable-set 0x10, enable-clear 0x18, poke 0x20. In the control word, bits [1:0] hold the mode, bits [19:4] hold the reload length and bits [43:20] read the live 24-bit count. Writes to the count bits are ignored.
- R3: While running, the count drops by one every PRESCALE input cycles (1024 by default). It holds still between those steps.
- R4: A control write with a nonzero mode clears the prescaler, starts at stage one, and loads the count with the length in its upper 16 bits and zeros in its lower 8 bits. A run-out happens on the step taken when the count is 0 or 1, and the count then reloads from the length. As a result, each stage lasts max(len*256,1) steps.
- R5: In mode 1, every run-out sets the CPU pending bit.
- R6: In mode 2, the first run-out sets the CPU pending bit. The second run-out and every later one set the management pending bit. No reset is ever requested.
- R7: In mode 3, the three run-outs give, in order: CPU pending, management pending, and a one-cycle `rst_req` pulse. After the pulse the timer holds in a fired state with a frozen count and raises no further events until the control word is written.
- R8: When the management enable is off, the second run-out leaves management pending clear but still advances the stage, so the third run-out still requests reset.
- R9: A poke write of exactly 1 while the timer is running reloads the count, clears the prescaler and returns to stage one. A poke of any other value is ignored, and so is any poke while the timer is stopped or fired.
- R10: Pending bit 0 is CPU and bit 1 is management. Writing 1 to a pending bit clears it. A run-out in the same cycle wins over the clear.
- R11: Enable bit 0 is CPU and bit 1 is management. Writing 1 to a bit in enable-set sets that enable, and writing 1 to a bit in enable-clear clears it. Both addresses read the enables. Each interrupt output equals its pending bit ANDed with its enable. CPU pending is set even while the CPU enable is off.
- R12: A control write with mode 0 stops the timer. The count freezes, the prescaler clears, the stage becomes idle, and no further events occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Byte address of the register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr` (combinational) |
| irq_cpu | output | 1 | CPU interrupt level |
| irq_mgmt | output | 1 | Management-processor interrupt level |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that a write strobe targets at most one register in a cycle. They also assume that the mode field changes only through a control write, which restarts or halts the sequence, so the stage can never disagree with the mode. The bench keeps within these limits: it drives one write per task at the falling edge, releases the strobe after the capturing edge, and stops the timer before every change of scenario. It overrides PRESCALE to 4 so that full three-stage escalations fit in short runs, and it predicts every run-out edge from the length, the prescale and the edge on which the last reload was captured.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_CPU  = 2'd1,
        MODE_MGMT = 2'd2,
        MODE_FULL = 2'd3
    } wdt_mode_e;

    typedef enum logic [2:0] {
        STG_IDLE   = 3'd0,
        STG_FIRST  = 3'd1,
        STG_SECOND = 3'd2,
        STG_THIRD  = 3'd3,
        STG_FIRED  = 3'd4
    } wdt_stage_e;

    // word indices (byte address >> 3)
    localparam int WORD_CTRL  = 0;
    localparam int WORD_PEND  = 1;
    localparam int WORD_ENSET = 2;
    localparam int WORD_ENCLR = 3;
    localparam int WORD_POKE  = 4;

    localparam int IRQ_NUM  = 2;
    localparam int IRQ_CPU  = 0;
    localparam int IRQ_MGMT = 1;

    localparam int MODE_W  = 2;
    localparam int LEN_LSB = 4;

endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int DIV = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (clr || !run) begin
            div_d = '0;
        end else if (div_q == LAST) begin
            div_d = '0;
        end else begin
            div_d = div_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign tick = run && !clr && (div_q == LAST);

    // two steps are never back to back when DIV >= 2
    assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/wdt_sequencer.sv
module wdt_sequencer
    import wdt_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int LOW_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  wdt_mode_e               mode,
    input  logic                    restart,
    input  logic                    halt,
    input  logic [LEN_W-1:0]        start_len,
    input  logic [LEN_W-1:0]        cur_len,
    input  logic                    tick,
    output logic                    running,
    output logic [LEN_W+LOW_W-1:0]  count,
    output logic                    ev_cpu,
    output logic                    ev_mgmt,
    output logic                    rst_req
);
    localparam int CNT_W = LEN_W + LOW_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        wdt_stage_e       stage;
        logic             rst;
    } seq_t;

    seq_t seq_d, seq_q;

    function automatic logic [CNT_W-1:0] widen(input logic [LEN_W-1:0] l);
        return {l, {LOW_W{1'b0}}};
    endfunction

    assign running = (seq_q.stage == STG_FIRST) || (seq_q.stage == STG_SECOND) ||
                     (seq_q.stage == STG_THIRD);

    always_comb begin
        seq_d     = seq_q;
        seq_d.rst = 1'b0;
        ev_cpu    = 1'b0;
        ev_mgmt   = 1'b0;
        if (halt) begin
            seq_d.stage = STG_IDLE;
        end else if (restart) begin
            seq_d.cnt   = widen(start_len);
            seq_d.stage = STG_FIRST;
        end else if (running && tick) begin
            if (seq_q.cnt <= CNT_W'(1)) begin
                seq_d.cnt = widen(cur_len);
                case (seq_q.stage)
                    STG_FIRST: begin
                        ev_cpu      = 1'b1;
                        seq_d.stage = (mode == MODE_CPU) ? STG_FIRST : STG_SECOND;
                    end
                    STG_SECOND: begin
                        ev_mgmt     = 1'b1;
                        seq_d.stage = (mode == MODE_FULL) ? STG_THIRD : STG_SECOND;
                    end
                    STG_THIRD: begin
                        seq_d.rst   = 1'b1;
                        seq_d.stage = STG_FIRED;
                    end
                    default: seq_d.stage = seq_q.stage;
                endcase
            end else begin
                seq_d.cnt = seq_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.cnt   <= '0;
            seq_q.stage <= STG_IDLE;
            seq_q.rst   <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign count   = seq_q.cnt;
    assign rst_req = seq_q.rst;

    assert_rst_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_fired_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.stage == STG_FIRED && !halt && !restart) |=>
            (seq_q.stage == STG_FIRED && $stable(count)));

    assert_idle_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.stage == STG_IDLE && !restart) |=> $stable(count));

    assert_step_only_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !tick && !restart && !halt) |=> $stable(count));

    assert_no_reset_mode1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CPU && !restart && !halt) |=> !rst_req);

endmodule

// File: rtl/wdt_irq_ctrl.sv
module wdt_irq_ctrl #(
    parameter int                 N_IRQ = 2,
    parameter logic [N_IRQ-1:0]   GATED = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] ev,
    input  logic [N_IRQ-1:0] pend_clr,
    input  logic [N_IRQ-1:0] en_set,
    input  logic [N_IRQ-1:0] en_clr,
    output logic [N_IRQ-1:0] pend,
    output logic [N_IRQ-1:0] en,
    output logic [N_IRQ-1:0] irq
);
    typedef struct packed {
        logic [N_IRQ-1:0] pend;
        logic [N_IRQ-1:0] en;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d.en = (st_q.en | en_set) & ~en_clr;
        for (int i = 0; i < N_IRQ; i++) begin
            st_d.pend[i] = (st_q.pend[i] & ~pend_clr[i]) |
                           (ev[i] & (!GATED[i] | st_q.en[i]));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
    assign en   = st_q.en;

    for (genvar ch = 0; ch < N_IRQ; ch++) begin : g_ch
        assign irq[ch] = st_q.pend[ch] & st_q.en[ch];

        assert_pend_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[ch]) |-> $past(ev[ch]));

        assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_clr[ch] && !ev[ch]) |=> !pend[ch]);

        assert_en_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (en_set[ch] && !en_clr[ch]) |=> en[ch]);

        if (GATED[ch]) begin : g_gate
            assert_gated_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (ev[ch] && !en[ch] && !pend[ch] && !en_set[ch]) |=> !pend[ch]);
        end
    end

endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate
    import wdt_pkg::*;
#(
    parameter int PRESCALE = 1024,
    parameter int LEN_W    = 16,
    parameter int LOW_W    = 8,
    parameter int ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic              irq_cpu,
    output logic              irq_mgmt,
    output logic              rst_req
);
    localparam int CNT_W   = LEN_W + LOW_W;
    localparam int CNT_LSB = LEN_LSB + LEN_W;
    localparam int WORD_W  = ADDR_W - 3;

    typedef struct packed {
        wdt_mode_e        mode;
        logic [LEN_W-1:0] len;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [WORD_W-1:0] word;
    logic              aligned;
    logic              wr_ctrl, wr_pend, wr_enset, wr_enclr, wr_poke;
    wdt_mode_e         new_mode;
    logic [LEN_W-1:0]  new_len, start_len;
    logic              restart, halt, poke_ok, running, tick;
    logic [CNT_W-1:0]  count;
    logic              ev_cpu, ev_mgmt;
    logic [IRQ_NUM-1:0] pend, en, irq, pend_clr, en_set, en_clr;

    assign word     = reg_addr[ADDR_W-1:3];
    assign aligned  = (reg_addr[2:0] == 3'b000);
    assign wr_ctrl  = reg_wr && aligned && (word == WORD_W'(WORD_CTRL));
    assign wr_pend  = reg_wr && aligned && (word == WORD_W'(WORD_PEND));
    assign wr_enset = reg_wr && aligned && (word == WORD_W'(WORD_ENSET));
    assign wr_enclr = reg_wr && aligned && (word == WORD_W'(WORD_ENCLR));
    assign wr_poke  = reg_wr && aligned && (word == WORD_W'(WORD_POKE));

    assign new_mode = wdt_mode_e'(reg_wdata[MODE_W-1:0]);
    assign new_len  = reg_wdata[LEN_LSB +: LEN_W];

    assign poke_ok   = wr_poke && (reg_wdata == 64'd1) && running;
    assign restart   = (wr_ctrl && new_mode != MODE_OFF) || poke_ok;
    assign halt      = wr_ctrl && new_mode == MODE_OFF;
    assign start_len = wr_ctrl ? new_len : cfg_q.len;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_ctrl) begin
            cfg_d.mode = new_mode;
            cfg_d.len  = new_len;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.mode <= MODE_OFF;
            cfg_q.len  <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    wdt_prescale #(.DIV(PRESCALE)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .clr   (restart || halt),
        .tick  (tick)
    );

    wdt_sequencer #(.LEN_W(LEN_W), .LOW_W(LOW_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (cfg_q.mode),
        .restart   (restart),
        .halt      (halt),
        .start_len (start_len),
        .cur_len   (cfg_q.len),
        .tick      (tick),
        .running   (running),
        .count     (count),
        .ev_cpu    (ev_cpu),
        .ev_mgmt   (ev_mgmt),
        .rst_req   (rst_req)
    );

    assign pend_clr = wr_pend  ? reg_wdata[IRQ_NUM-1:0] : '0;
    assign en_set   = wr_enset ? reg_wdata[IRQ_NUM-1:0] : '0;
    assign en_clr   = wr_enclr ? reg_wdata[IRQ_NUM-1:0] : '0;

    wdt_irq_ctrl #(.N_IRQ(IRQ_NUM), .GATED(IRQ_NUM'(1 << IRQ_MGMT))) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       ({ev_mgmt, ev_cpu}),
        .pend_clr (pend_clr),
        .en_set   (en_set),
        .en_clr   (en_clr),
        .pend     (pend),
        .en       (en),
        .irq      (irq)
    );

    assign irq_cpu  = irq[IRQ_CPU];
    assign irq_mgmt = irq[IRQ_MGMT];

    always_comb begin
        reg_rdata = '0;
        if (aligned) begin
            if (word == WORD_W'(WORD_CTRL)) begin
                reg_rdata[MODE_W-1:0]        = cfg_q.mode;
                reg_rdata[LEN_LSB +: LEN_W]  = cfg_q.len;
                reg_rdata[CNT_LSB +: CNT_W]  = count;
            end else if (word == WORD_W'(WORD_PEND)) begin
                reg_rdata[IRQ_NUM-1:0] = pend;
            end else if (word == WORD_W'(WORD_ENSET) || word == WORD_W'(WORD_ENCLR)) begin
                reg_rdata[IRQ_NUM-1:0] = en;
            end
        end
    end

    assert_reload_fmt_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count == {$past(start_len), {LOW_W{1'b0}}}));

    assert_bad_poke_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_poke && reg_wdata != 64'd1 && running && !tick) |=> $stable(count));

    assert_halt_stops_R12: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !running);

endmodule

// File: tb/sim_wdt_escalate.sv
`timescale 1ns/1ps
module sim_wdt_escalate;
    localparam int PRE = 4;
    localparam logic [7:0] A_CTRL = 8'h00, A_PEND = 8'h08, A_ENSET = 8'h10,
                           A_ENCLR = 8'h18, A_POKE = 8'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        irq_cpu, irq_mgmt, rst_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdt_escalate #(.PRESCALE(PRE)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_cpu(irq_cpu), .irq_mgmt(irq_mgmt), .rst_req(rst_req)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [63:0] ctrl_val(input int m, input int l, input int c);
        return (64'(c) << 20) | (64'(l) << 4) | 64'(m);
    endfunction

    function automatic logic [63:0] cnt_of(input logic [63:0] v);
        return (v >> 20) & 64'hFF_FFFF;
    endfunction

    task automatic park();
        wr(A_CTRL, 64'd0);
        wr(A_PEND, 64'd3);
    endtask

    task automatic t_reset();
        logic [63:0] v;
        chk("R1 irq_cpu", irq_cpu, 0);
        chk("R1 irq_mgmt", irq_mgmt, 0);
        chk("R1 rst_req", rst_req, 0);
        rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
        rd(A_PEND, v);  chk("R1 pend", v, 0);
        rd(A_ENSET, v); chk("R1 en", v, 0);
    endtask

    task automatic t_layout();
        logic [63:0] v;
        wr(A_CTRL, (64'hABCDEF << 20) | (64'd2 << 4) | 64'd1);
        rd(A_CTRL, v); chk("R2 count write ignored / R4 reload", v, ctrl_val(1, 2, 512));
        wait_edges(40);
        rd(A_CTRL, v); chk("R3 ten steps", cnt_of(v), 502);
        wait_edges(3);
        rd(A_CTRL, v); chk("R3 hold between steps", cnt_of(v), 502);
        wait_edges(1);
        rd(A_CTRL, v); chk("R3 next step", cnt_of(v), 501);
        park();
    endtask

    task automatic t_mode1();
        logic [63:0] v;
        wr(A_ENSET, 64'd1);
        wr(A_CTRL, ctrl_val(1, 1, 0));
        wait_edges(1023); chk("R4 not yet expired", irq_cpu, 0);
        wait_edges(1);    chk("R5 first expiry", irq_cpu, 1);
        rd(A_PEND, v);    chk("R10 pend bit0", v, 1);
        wr(A_PEND, 64'd1);
        chk("R10 w1c drops irq", irq_cpu, 0);
        rd(A_PEND, v);    chk("R10 pend cleared", v, 0);
        wait_edges(1022); chk("R5 before second expiry", irq_cpu, 0);
        wait_edges(1);    chk("R5 second expiry", irq_cpu, 1);
        park();
    endtask

    task automatic t_len_zero();
        logic [63:0] v;
        wr(A_ENCLR, 64'd3);
        wr(A_CTRL, ctrl_val(1, 0, 0));
        wait_edges(3);
        rd(A_PEND, v);    chk("R4 len0 before first step", v, 0);
        wait_edges(1);
        rd(A_PEND, v);    chk("R11 pend set while disabled", v, 1);
        chk("R11 irq masked", irq_cpu, 0);
        wr(A_ENSET, 64'd1);
        chk("R11 enable set raises irq", irq_cpu, 1);
        rd(A_ENSET, v);   chk("R11 read enset", v, 1);
        rd(A_ENCLR, v);   chk("R11 read enclr", v, 1);
        wr(A_ENCLR, 64'd1);
        chk("R11 enable clear drops irq", irq_cpu, 0);
        rd(A_ENSET, v);   chk("R11 enable cleared", v, 0);
        park();
    endtask

    task automatic t_mode3();
        logic [63:0] v;
        wr(A_ENSET, 64'd3);
        wr(A_CTRL, ctrl_val(3, 1, 0));
        wait_edges(1023); chk("R7 cpu not yet", irq_cpu, 0);
        wait_edges(1);    chk("R7 cpu stage", irq_cpu, 1);
        chk("R7 mgmt not at stage one", irq_mgmt, 0);
        wait_edges(1023); chk("R7 mgmt not yet", irq_mgmt, 0);
        wait_edges(1);    chk("R7 mgmt stage", irq_mgmt, 1);
        wait_edges(1023); chk("R7 reset not yet", rst_req, 0);
        wait_edges(1);    chk("R7 reset pulse", rst_req, 1);
        wait_edges(1);    chk("R7 reset one cycle", rst_req, 0);
        wait_edges(2000);
        rd(A_CTRL, v);    chk("R7 fired count frozen", cnt_of(v), 256);
        wr(A_POKE, 64'd1);
        wait_edges(1100);
        chk("R9 poke while fired no reset", rst_req, 0);
        rd(A_CTRL, v);    chk("R9 poke while fired ignored", cnt_of(v), 256);
        park();
    endtask

    task automatic t_mgmt_off();
        logic [63:0] v;
        wr(A_ENSET, 64'd1);
        wr(A_ENCLR, 64'd2);
        wr(A_CTRL, ctrl_val(3, 1, 0));
        wait_edges(2048);
        chk("R8 no mgmt output", irq_mgmt, 0);
        rd(A_PEND, v);    chk("R8 mgmt pend stays clear", v, 1);
        wait_edges(1023); chk("R8 reset not yet", rst_req, 0);
        wait_edges(1);    chk("R8 stage still advanced", rst_req, 1);
        park();
    endtask

    task automatic t_mode2();
        wr(A_ENSET, 64'd3);
        wr(A_CTRL, ctrl_val(2, 1, 0));
        wait_edges(1024); chk("R6 cpu first", irq_cpu, 1);
        wait_edges(1024); chk("R6 mgmt second", irq_mgmt, 1);
        wr(A_PEND, 64'd2);
        chk("R10 mgmt w1c", irq_mgmt, 0);
        wait_edges(1022); chk("R6 before third", irq_mgmt, 0);
        wait_edges(1);    chk("R6 mgmt repeats", irq_mgmt, 1);
        chk("R6 never reset", rst_req, 0);
        park();
    endtask

    task automatic t_poke();
        logic [63:0] v;
        wr(A_ENSET, 64'd1);
        wr(A_CTRL, ctrl_val(3, 1, 0));
        wait_edges(500);
        wr(A_POKE, 64'd2);
        rd(A_CTRL, v);    chk("R9 poke value 2 ignored", cnt_of(v), 131);
        wr(A_POKE, 64'd1);
        rd(A_CTRL, v);    chk("R9 poke reloads", cnt_of(v), 256);
        wait_edges(522);  chk("R9 old deadline passed quietly", irq_cpu, 0);
        wait_edges(501);  chk("R9 new deadline not yet", irq_cpu, 0);
        wait_edges(1);    chk("R9 new deadline", irq_cpu, 1);
        park();
    endtask

    task automatic t_stop();
        logic [63:0] v;
        wr(A_ENSET, 64'd1);
        wr(A_CTRL, ctrl_val(1, 1, 0));
        wait_edges(100);
        wr(A_CTRL, ctrl_val(0, 1, 0));
        rd(A_CTRL, v);    chk("R12 stop freezes", v, ctrl_val(0, 1, 231));
        wait_edges(2000);
        rd(A_CTRL, v);    chk("R12 still frozen", v, ctrl_val(0, 1, 231));
        chk("R12 no irq while stopped", irq_cpu, 0);
        wr(A_POKE, 64'd1);
        rd(A_CTRL, v);    chk("R9 poke while stopped ignored", v, ctrl_val(0, 1, 231));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        wait_edges(1);
        t_reset();
        t_layout();
        t_mode1();
        t_len_zero();
        t_mode3();
        t_mgmt_off();
        t_mode2();
        t_poke();
        t_stop();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule